// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit sits beside the integer datapath of a 64-bit RISC core. It takes multiply and divide work that is too slow for one cycle. A request is one cycle with `start` high, a 4-bit operation code and two 64-bit source operands. The unit then computes over several cycles. Multiplication retires eight multiplier bits per cycle. Division is a restoring divider that produces one quotient bit per cycle. Signed operations work on operand magnitudes and correct the signs in a final cycle.

The unit owns the HI and LO result registers. A plain multiply writes the upper half of its product to HI and the lower half to LO. A divide writes the quotient to LO and the remainder to HI. The accumulate forms add their 64-bit product to the pair held in HI/LO, and the subtract forms remove it. A three-operand form returns the low product word on `result` and leaves HI/LO alone. The 32-bit forms use the low 32 bits of each source and store each 32-bit answer sign-extended to 64 bits.

Top module: `iter_muldiv`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `hi`, `lo` and `result` are all zero.
- R2: Operation codes: 0 signed 32-bit multiply, 1 unsigned 32-bit multiply, 2 signed 64-bit multiply, 3 unsigned 64-bit multiply, 4 signed 32-bit divide, 5 unsigned 32-bit divide, 6 signed 64-bit divide, 7 unsigned 64-bit divide, 8 signed multiply-add, 9 unsigned multiply-add, 10 signed multiply-subtract, 11 unsigned multiply-subtract, 12 signed three-operand multiply. A `start` with codes 0..12 while `busy` is low begins an operation. A `start` with codes 13..15 is ignored: `busy` stays low and HI/LO do not change.
- R3: Every multiply-type operation (codes 0..3 and 8..12) keeps `busy` high for exactly 5 consecutive cycles in its 32-bit form and for 9 in its 64-bit form (codes 2 and 3). `done` is high in the cycle that follows.
- R4: Every divide keeps `busy` high for exactly 34 consecutive cycles in its 32-bit form and for 66 in its 64-bit form. `done` is high in the cycle that follows.
- R5: A 64-bit multiply leaves bits 127..64 of the 128-bit product in `hi` and bits 63..0 in `lo`. A 32-bit multiply leaves product bits 63..32 in `hi` and bits 31..0 in `lo`, each sign-extended to 64 bits. Signed forms treat their sources as two's complement.
- R6: A divide leaves the quotient, rounded toward zero, in `lo` and the remainder in `hi`. In signed form the quotient is negated when the source signs differ, and the remainder has the sign of the dividend. The 32-bit forms store both sign-extended.
- R7: Multiply-add computes {hi[31:0], lo[31:0]} plus the 64-bit product of the low source words. Multiply-subtract computes the same pair minus that product. Bits 63..32 of the sum go to `hi` and bits 31..0 to `lo`, each sign-extended.
- R8: Code 12 puts the low 32 product bits, sign-extended, on `result` and leaves `hi`/`lo` unchanged. Every other operation copies its new `lo` value to `result`.
- R9: A `start` while `busy` is high is ignored, and the running operation finishes with its own latency and results. `done` is a one-cycle pulse, `busy` is low while `done` is high, and `hi`/`lo` change only in a `done` cycle.
- R10: Division by zero takes the normal cycle count and raises no error. Its result is fixed: the quotient magnitude is all ones over the operation width and the remainder magnitude is the dividend magnitude. The signed corrections of R6 then apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| op | input | 4 | Operation code (see R2) |
| src_a | input | 64 | First operand / dividend |
| src_b | input | 64 | Second operand / divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Direct result word |
| hi | output | 64 | HI register |
| lo | output | 64 | LO register |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath and an 8-bit multiply radix. This gives the 5/9 multiply and 34/66 divide latencies and the full 128-bit product. The 64-bit width lets directed cases reach the most negative 32-bit and 64-bit dividends divided by minus one, and signed division with every sign combination of dividend and divisor. The same build also reaches division by zero in both widths, accumulate chains that carry across the 32-bit boundary, and a request dropped partway through a long divide.

// File: rtl/imdu_pkg.sv
// Shared definitions for the iterative multiply/divide unit.
// Assumes a 4-bit operation code whose bit layout is decoded below.
package imdu_pkg;

    typedef enum logic [3:0] {
        OP_MULW   = 4'd0,
        OP_MULWU  = 4'd1,
        OP_MULD   = 4'd2,
        OP_MULDU  = 4'd3,
        OP_DIVW   = 4'd4,
        OP_DIVWU  = 4'd5,
        OP_DIVD   = 4'd6,
        OP_DIVDU  = 4'd7,
        OP_MACW   = 4'd8,
        OP_MACWU  = 4'd9,
        OP_MSBW   = 4'd10,
        OP_MSBWU  = 4'd11,
        OP_MULLO  = 4'd12
    } imdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIX  = 2'd3
    } imdu_st_e;

    typedef struct packed {
        logic is_div;
        logic wide;
        logic uns;
        logic acc;
        logic sub;
        logic lo_only;
    } imdu_dec_t;

    // Split an operation code into its control flags.
    function automatic imdu_dec_t imdu_decode(input logic [3:0] code);
        imdu_dec_t d;
        d.is_div  = (code[3:2] == 2'b01);
        d.wide    = !code[3] && code[1];
        d.uns     = code[0];
        d.acc     = (code[3:2] == 2'b10);
        d.sub     = (code[3:2] == 2'b10) && code[1];
        d.lo_only = (code == OP_MULLO);
        return d;
    endfunction

    // True for the codes the unit executes.
    function automatic logic imdu_valid(input logic [3:0] code);
        return code <= OP_MULLO;
    endfunction

endpackage

// File: rtl/imdu_seq.sv
// Sequencer: walks IDLE -> (PREP for divides) -> RUN x steps -> FIX -> IDLE.
// Assumes the decode flags for a new request are valid in the accept cycle.
module imdu_seq #(
    parameter int XLEN  = 64,
    parameter int RADIX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic acc_div,
    input  logic acc_wide,
    output logic busy,
    output logic done,
    output logic prep_en,
    output logic step_en,
    output logic fix_en
);
    import imdu_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);
    localparam logic [CW-1:0] N_MUL_W = CW'(HALF / RADIX);
    localparam logic [CW-1:0] N_MUL_D = CW'(XLEN / RADIX);
    localparam logic [CW-1:0] N_DIV_W = CW'(HALF);
    localparam logic [CW-1:0] N_DIV_D = CW'(XLEN);

    imdu_st_e        st;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   load_n;

    // Number of iteration steps for the incoming request.
    always_comb begin
        if (acc_div) load_n = acc_wide ? N_DIV_D : N_DIV_W;
        else         load_n = acc_wide ? N_MUL_D : N_MUL_W;
    end

    // State, step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= (st == ST_FIX);
            case (st)
                ST_IDLE: if (accept) begin
                    cnt <= load_n;
                    st  <= acc_div ? ST_PREP : ST_RUN;
                end
                ST_PREP: st <= ST_RUN;
                ST_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CW'(1)) st <= ST_FIX;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign prep_en = (st == ST_PREP);
    assign step_en = (st == ST_RUN);
    assign fix_en  = (st == ST_FIX);
endmodule

// File: rtl/imdu_mul_core.sv
// Radix-2^RADIX magnitude multiplier: each step adds multiplicand * digit.
// Assumes unsigned operands; sign correction is done by the caller.
module imdu_mul_core #(
    parameter int XLEN  = 64,
    parameter int RADIX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] prod
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   pp;
    logic [XLEN-1:0] mq;
    logic [PW-1:0]   partial;

    assign partial = pp * PW'(mq[RADIX-1:0]);

    // Load operands, then accumulate one digit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp   <= '0;
            mq   <= '0;
            prod <= '0;
        end else if (load) begin
            pp   <= PW'(mcand);
            mq   <= mplier;
            prod <= '0;
        end else if (step) begin
            prod <= prod + partial;
            pp   <= pp << RADIX;
            mq   <= mq >> RADIX;
        end
    end
endmodule

// File: rtl/imdu_div_core.sv
// Restoring magnitude divider, one quotient bit per step.
// Narrow mode pre-shifts the dividend so HALF steps consume it.
module imdu_div_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prep,
    input  logic            step,
    input  logic            wide,
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] dvs_r;
    logic [XLEN:0]   shifted;
    logic [XLEN+1:0] trial;

    assign shifted = {rem, quo[XLEN-1]};
    assign trial   = {1'b0, shifted} - {2'b00, dvs_r};

    // Align operands, then shift-subtract-restore each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo   <= '0;
            rem   <= '0;
            dvs_r <= '0;
        end else if (prep) begin
            rem   <= '0;
            quo   <= wide ? dvd : (dvd << HALF);
            dvs_r <= dvs;
        end else if (step) begin
            if (!trial[XLEN+1]) begin
                rem <= trial[XLEN-1:0];
                quo <= {quo[XLEN-2:0], 1'b1};
            end else begin
                rem <= shifted[XLEN-1:0];
                quo <= {quo[XLEN-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/iter_muldiv.sv
// Top of the iterative multiply/divide unit: operand conditioning,
// sign correction and HI/LO/result update. Requests are taken only while idle.
module iter_muldiv #(
    parameter int XLEN  = 64,
    parameter int RADIX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo
);
    import imdu_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    // Sign-extend a half word to full width.
    function automatic logic [XLEN-1:0] sx(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction

    // Extend an operand to full width per size and signedness.
    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] x,
                                              input logic w, input logic u);
        if (w)      return x;
        else if (u) return {{HALF{1'b0}}, x[HALF-1:0]};
        else        return sx(x[HALF-1:0]);
    endfunction

    imdu_dec_t       dec_in;
    logic            accept;
    logic [XLEN-1:0] ext_a, ext_b, mag_a, mag_b;
    logic            sgn_a, sgn_b;

    logic            r_div, r_wide, r_acc, r_sub, r_lo;
    logic            na_r, nb_r;
    logic [XLEN-1:0] amag_r, bmag_r;

    logic            prep_en, step_en, fix_en;
    logic [PW-1:0]   prod_mag, prod_s;
    logic [XLEN-1:0] quo, rem, q_full, q_s, r_s;
    logic [XLEN-1:0] acc_base, acc_new;
    logic [XLEN-1:0] hi_nx, lo_nx, res_nx;

    assign dec_in = imdu_decode(op);
    assign accept = start && !busy && imdu_valid(op);

    // Operand magnitudes and signs for the incoming request.
    always_comb begin
        ext_a = widen(src_a, dec_in.wide, dec_in.uns);
        ext_b = widen(src_b, dec_in.wide, dec_in.uns);
        sgn_a = !dec_in.uns && ext_a[XLEN-1];
        sgn_b = !dec_in.uns && ext_b[XLEN-1];
        mag_a = sgn_a ? -ext_a : ext_a;
        mag_b = sgn_b ? -ext_b : ext_b;
    end

    // Capture the request attributes at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {r_div, r_wide, r_acc, r_sub, r_lo, na_r, nb_r} <= '0;
            amag_r <= '0;
            bmag_r <= '0;
        end else if (accept) begin
            r_div  <= dec_in.is_div;
            r_wide <= dec_in.wide;
            r_acc  <= dec_in.acc;
            r_sub  <= dec_in.sub;
            r_lo   <= dec_in.lo_only;
            na_r   <= sgn_a;
            nb_r   <= sgn_b;
            amag_r <= mag_a;
            bmag_r <= mag_b;
        end
    end

    imdu_seq #(.XLEN(XLEN), .RADIX(RADIX)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .acc_div(dec_in.is_div), .acc_wide(dec_in.wide),
        .busy(busy), .done(done),
        .prep_en(prep_en), .step_en(step_en), .fix_en(fix_en)
    );

    imdu_mul_core #(.XLEN(XLEN), .RADIX(RADIX)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(accept && !dec_in.is_div),
        .step(step_en && !r_div), .mcand(mag_a), .mplier(mag_b),
        .prod(prod_mag)
    );

    imdu_div_core #(.XLEN(XLEN)) u_div (
        .clk(clk), .rst_n(rst_n), .prep(prep_en),
        .step(step_en && r_div), .wide(r_wide),
        .dvd(amag_r), .dvs(bmag_r), .quo(quo), .rem(rem)
    );

    // Final sign correction and selection of the values to write back.
    always_comb begin
        prod_s   = (na_r ^ nb_r) ? -prod_mag : prod_mag;
        q_full   = r_wide ? quo : {{HALF{1'b0}}, quo[HALF-1:0]};
        q_s      = (na_r ^ nb_r) ? -q_full : q_full;
        r_s      = na_r ? -rem : rem;
        acc_base = {hi[HALF-1:0], lo[HALF-1:0]};
        acc_new  = r_sub ? acc_base - prod_s[XLEN-1:0]
                         : acc_base + prod_s[XLEN-1:0];
        hi_nx    = hi;
        lo_nx    = lo;
        if (r_div) begin
            hi_nx = r_wide ? r_s : sx(r_s[HALF-1:0]);
            lo_nx = r_wide ? q_s : sx(q_s[HALF-1:0]);
        end else if (r_acc) begin
            hi_nx = sx(acc_new[XLEN-1:HALF]);
            lo_nx = sx(acc_new[HALF-1:0]);
        end else if (!r_lo) begin
            hi_nx = r_wide ? prod_s[PW-1:XLEN] : sx(prod_s[XLEN-1:HALF]);
            lo_nx = r_wide ? prod_s[XLEN-1:0]  : sx(prod_s[HALF-1:0]);
        end
        res_nx = r_lo ? sx(prod_s[HALF-1:0]) : lo_nx;
    end

    // HI/LO/result registers, written only in the fix cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi     <= '0;
            lo     <= '0;
            result <= '0;
        end else if (fix_en) begin
            hi     <= hi_nx;
            lo     <= lo_nx;
            result <= res_nx;
        end
    end
endmodule

// File: rtl/imdu_chk.sv
// Protocol and latency checker for iter_muldiv, attached by bind.
// Tracks busy cycles from acceptance with its own counter.
module imdu_chk #(
    parameter int XLEN  = 64,
    parameter int RADIX = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      op,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] hi,
    input logic [XLEN-1:0] lo
);
    localparam int HALF = XLEN / 2;

    logic        take;
    logic        exp_div;
    logic [15:0] exp_n;
    logic [15:0] cnt;

    assign take = start && !busy && (op <= 4'd12);

    // Expected busy length of the accepted request, and busy cycles seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_div <= 1'b0;
            exp_n   <= '0;
            cnt     <= '0;
        end else if (take) begin
            cnt     <= '0;
            exp_div <= (op[3:2] == 2'b01);
            if (op[3:2] == 2'b01)
                exp_n <= op[1] ? 16'(XLEN + 2) : 16'(HALF + 2);
            else
                exp_n <= (!op[3] && op[1]) ? 16'(XLEN / RADIX + 1)
                                           : 16'(HALF / RADIX + 1);
        end else if (busy) begin
            cnt <= cnt + 16'd1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);                                             // R2
    AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op > 4'd12) |=> !busy);                  // R2
    AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !exp_div) |-> cnt == exp_n);                       // R3
    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exp_div) |-> cnt == exp_n);                        // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R9
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);                                            // R9
    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo)));                    // R9
endmodule

bind iter_muldiv imdu_chk #(.XLEN(XLEN), .RADIX(RADIX)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/iter_muldiv_tb.sv
`timescale 1ns/1ps
module iter_muldiv_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        busy, done;
    logic [63:0] result, hi, lo;

    int errs = 0;
    int checks = 0;
    logic [63:0] m_hi = '0, m_lo = '0, m_res = '0;

    always #2.5 clk = ~clk;

    iter_muldiv u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .result(result), .hi(hi), .lo(lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [127:0] ext128(input logic [63:0] x, input bit w, input bit u);
        if (w) return u ? {64'd0, x} : {{64{x[63]}}, x};
        return u ? {96'd0, x[31:0]} : {{96{x[31]}}, x[31:0]};
    endfunction

    // Reference model per R5..R8, R10; updates m_hi/m_lo/m_res.
    task automatic model(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
        bit u = c[0];
        bit w = !c[3] && c[1];
        logic [127:0] p, ea, eb;
        logic [63:0] base, n, ma, mb, q, r;
        bit na, nb;
        ea = ext128(a, w, u);
        eb = ext128(b, w, u);
        p  = ea * eb;
        if (c == 4'd12) begin
            m_res = sx32(p[31:0]);
        end else if (c[3:2] == 2'b01) begin
            na = !u && ea[127];
            nb = !u && eb[127];
            ma = na ? -ea[63:0] : ea[63:0];
            mb = nb ? -eb[63:0] : eb[63:0];
            if (mb == 64'd0) begin
                q = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
                r = ma;
            end else begin
                q = ma / mb;
                r = ma % mb;
            end
            if (na ^ nb) q = -q;
            if (na) r = -r;
            m_hi = w ? r : sx32(r[31:0]);
            m_lo = w ? q : sx32(q[31:0]);
            m_res = m_lo;
        end else if (c[3:2] == 2'b10) begin
            base = {m_hi[31:0], m_lo[31:0]};
            n = c[1] ? base - p[63:0] : base + p[63:0];
            m_hi = sx32(n[63:32]);
            m_lo = sx32(n[31:0]);
            m_res = m_lo;
        end else begin
            m_hi = w ? p[127:64] : sx32(p[63:32]);
            m_lo = w ? p[63:0] : sx32(p[31:0]);
            m_res = m_lo;
        end
    endtask

    function automatic int exp_len(input logic [3:0] c);
        if (c[3:2] == 2'b01) return c[1] ? 66 : 34;
        return (!c[3] && c[1]) ? 9 : 5;
    endfunction

    function automatic string req_of(input logic [3:0] c);
        if (c == 4'd12) return "R8";
        if (c[3:2] == 2'b01) return "R6";
        if (c[3:2] == 2'b10) return "R7";
        return "R5";
    endfunction

    // Issue one request; optionally pulse a second start while busy (R9).
    task automatic run_op(input logic [3:0] c, input logic [63:0] a,
                          input logic [63:0] b, input bit poke);
        int n = 0;
        @(negedge clk);
        op = c; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model(c, a, b);
        while (busy) begin
            n++;
            if (poke && n == 3) begin
                op = 4'd2; src_a = 64'h1234; src_b = 64'h5678; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done === 1'b1, "R9", "done after busy", {63'd0, done}, 64'd1);
        chk(n == exp_len(c), (c[3:2] == 2'b01) ? "R4" : "R3", "busy cycles",
            64'(n), 64'(exp_len(c)));
        chk(hi === m_hi, req_of(c), "hi", hi, m_hi);
        chk(lo === m_lo, req_of(c), "lo", lo, m_lo);
        chk(result === m_res, "R8", "result", result, m_res);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done one cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R9 watchdog expired: actual=%h expected=%h", 64'd1, 64'd0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", {62'd0, busy, done}, 64'd0);
        chk(hi === 64'd0 && lo === 64'd0, "R1", "hi|lo", hi | lo, 64'd0);
        chk(result === 64'd0, "R1", "result", result, 64'd0);

        // R2: unused codes are ignored
        run_op(4'd2, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0007, 1'b0);
        for (int c = 13; c < 16; c++) begin
            @(negedge clk);
            op = 4'(c); src_a = 64'd5; src_b = 64'd6; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b0, "R2", "bad code busy", {63'd0, busy}, 64'd0);
            chk(hi === m_hi && lo === m_lo, "R2", "bad code lo", lo, m_lo);
        end

        // Directed multiplies (R5, R3)
        run_op(4'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1'b0);
        run_op(4'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0);
        run_op(4'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);

        // Directed divides: sign combinations and overflow corner (R6, R4)
        run_op(4'd4, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
        run_op(4'd4, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 1'b0);
        run_op(4'd4, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);
        run_op(4'd6, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 1'b0);
        run_op(4'd5, 64'h0000_0000_FFFF_FFFF, 64'd16, 1'b0);

        // R10: divide by zero, both widths and signedness
        run_op(4'd4, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 1'b0);
        run_op(4'd5, 64'h0000_0000_1234_5678, 64'd0, 1'b0);
        run_op(4'd6, 64'd100, 64'd0, 1'b0);
        run_op(4'd7, 64'hDEAD_BEEF_0000_0001, 64'd0, 1'b0);

        // R7: accumulate chain crossing 32-bit boundary, then subtract
        run_op(4'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0);
        run_op(4'd9, 64'hFFFF_FFFF, 64'd2, 1'b0);
        run_op(4'd8, 64'hFFFF_FFFF_8000_0000, 64'd3, 1'b0);
        run_op(4'd10, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op(4'd11, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0);

        // R8: three-operand multiply keeps HI/LO
        run_op(4'd12, 64'h0000_0000_7FFF_FFFF, 64'd3, 1'b0);

        // R9: start while busy ignored during long and short operations
        run_op(4'd6, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_1234, 1'b1);
        run_op(4'd0, 64'hFFFF_FFFF_FFFF_FF00, 64'd77, 1'b1);

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] c;
            logic [63:0] a, b;
            c = 4'($urandom % 13);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case ($urandom % 4)
                0: b = b & 64'hFF;
                1: a = a & 64'hFFFF;
                2: b = b | 64'h8000_0000_8000_0000;
                default: ;
            endcase
            run_op(c, a, b, ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule